// File: doc/BRIEF.md
# Buffer Length Control Conditioner

This block turns a noisy potentiometer reading, delivered by an ADC as a strobed 10-bit value, into a stable buffer length for an audio delay or reversal engine. Readings are summed over fixed blocks of 256 valid conversions. At the end of each block the sum is scaled down to a 16-bit length, raised to a floor if it is too small, and compared with the length currently in force. Only a change large enough to clear a deadband is taken over, and the stored target is always made even.

A second register, the active length, is what the audio datapath actually uses. It moves toward the target by a fixed step of 2 on each audio sample strobe. A large pot move therefore turns into a gradual ramp rather than a jump, and the rest of the audio chain never sees a sudden change in buffer size.

Top module: `buflen_ctrl`

## Requirements
- R1: After reset both the target length and the active length read 0x0600.
- R2: Only cycles with `adc_valid_i` high contribute a reading, and a block is evaluated only once 256 such readings have been taken. Data on cycles with the strobe low has no effect, and 255 readings leave the target unchanged.
- R3: The block result is the sum of its 256 readings shifted right by 2, taken as a 16-bit value.
- R4: A block result below 0x0200 is raised to 0x0200 before the deadband comparison.
- R5: The target takes a new value only when the absolute difference between the clamped result and the current target is 0x0040 or more. A difference of 0x003F leaves the target unchanged.
- R6: When the target is updated, bit 0 of the stored value is forced to 0, so the target is always even.
- R7: The running sum and the reading count restart from zero after every block, whether or not that block updated the target.
- R8: A new target appears on `target_len_o` after the second rising clock edge counted from the edge that captures the 256th reading. It does not appear after the first.
- R9: On a clock edge with `sample_i` high, the active length rises by 2 if it is below the target, falls by 2 if it is above, and holds if it is equal. Without the strobe it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| adc_valid_i | input | 1 | Marks a cycle that carries a new pot reading |
| adc_data_i | input | 10 | Unsigned pot reading |
| sample_i | input | 1 | Audio sample strobe, one step of the active length |
| target_len_o | output | 16 | Conditioned, even target buffer length |
| active_len_o | output | 16 | Rate-limited buffer length in use |

## Verification
The assertions watch the invariants that hold on every cycle. The target stays even and never falls below the floor. It moves only in the cycle after a block completes, and only by at least the deadband. The reading count holds when no reading arrives. The active length stays put without a strobe and moves by exactly one step in the right direction with one. The bench scenarios cover what a single-cycle invariant cannot see: the arithmetic of the shift and clamp on chosen sums, the exact edge of the deadband, the odd result that gets rounded down, the restart of the sum after a block that changed nothing, and the slewing of the active length in both directions until it meets the target.

// File: rtl/buflen_pkg.sv
package buflen_pkg;

  // Direction chosen by the slew stage for one audio sample
  typedef enum logic [1:0] {
    SLEW_HOLD = 2'd0,
    SLEW_UP   = 2'd1,
    SLEW_DOWN = 2'd2
  } slew_dir_e;

endpackage

// File: rtl/buflen_rst_sync.sv
module buflen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/buflen_accum.sv
module buflen_accum #(
  parameter int ADC_W     = 10,
  parameter int BLK_LOG2  = 8,
  localparam int ACC_W    = ADC_W + BLK_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_valid_i,
  input  logic [ADC_W-1:0] adc_data_i,
  output logic             blk_done_o,
  output logic [ACC_W-1:0] blk_sum_o
);

  localparam logic [BLK_LOG2-1:0] CNT_LAST = {BLK_LOG2{1'b1}};

  logic [ACC_W-1:0]    acc_q, acc_n;
  logic [BLK_LOG2-1:0] cnt_q, cnt_n;
  logic                done_q, done_n;
  logic [ACC_W-1:0]    sum_q, sum_n;
  logic [ACC_W-1:0]    acc_plus;
  logic                acc_en, sum_en;

  assign acc_plus = acc_q + ACC_W'(adc_data_i);

  always_comb begin
    acc_en = adc_valid_i;
    acc_n  = acc_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    sum_n  = sum_q;
    sum_en = 1'b0;
    if (adc_valid_i) begin
      if (cnt_q == CNT_LAST) begin
        acc_n  = '0;
        cnt_n  = '0;
        done_n = 1'b1;
        sum_n  = acc_plus;
        sum_en = 1'b1;
      end else begin
        acc_n  = acc_plus;
        cnt_n  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign blk_done_o = done_q;
  assign blk_sum_o  = sum_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_valid_i |=> $stable(cnt_q)); // R2
  AST_DONE_NEEDS_READING: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(adc_valid_i)); // R2
  AST_BLOCK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (acc_q == '0 && cnt_q == '0)); // R7

endmodule

// File: rtl/buflen_target.sv
module buflen_target #(
  parameter int              ACC_W     = 18,
  parameter int              LEN_W     = 16,
  parameter logic [LEN_W-1:0] MIN_LEN  = 16'h0200,
  parameter logic [LEN_W-1:0] DEADBAND = 16'h0040,
  parameter logic [LEN_W-1:0] INIT_LEN = 16'h0600,
  localparam int             SHIFT     = ACC_W - LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_done_i,
  input  logic [ACC_W-1:0] blk_sum_i,
  output logic [LEN_W-1:0] target_o
);

  logic [LEN_W-1:0] target_q, target_n;
  logic [LEN_W-1:0] scaled, clamped, abs_diff;
  logic             tgt_en;

  assign scaled  = blk_sum_i[SHIFT +: LEN_W];
  assign clamped = (scaled < MIN_LEN) ? MIN_LEN : scaled;

  always_comb begin
    abs_diff = (clamped >= target_q) ? (clamped - target_q) : (target_q - clamped);
    tgt_en   = blk_done_i && (abs_diff >= DEADBAND);
    target_n = {clamped[LEN_W-1:1], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      target_q <= INIT_LEN;
    else if (tgt_en) target_q <= target_n;
  end

  assign target_o = target_q;

  AST_TGT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    target_q[0] == 1'b0); // R6
  AST_TGT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    target_q >= MIN_LEN); // R4
  AST_TGT_ONLY_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_done_i |=> $stable(target_q)); // R8
  AST_TGT_MOVE_CLEARS_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (target_q != $past(target_q)) |->
      (((target_q > $past(target_q)) ? (target_q - $past(target_q))
                                     : ($past(target_q) - target_q)) >= DEADBAND)); // R5

endmodule

// File: rtl/buflen_slew.sv
module buflen_slew #(
  parameter int               LEN_W    = 16,
  parameter int               STEP     = 2,
  parameter logic [LEN_W-1:0] INIT_LEN = 16'h0600,
  localparam logic [LEN_W-1:0] STEP_V  = LEN_W'(STEP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic [LEN_W-1:0] target_i,
  output logic [LEN_W-1:0] active_o
);

  import buflen_pkg::*;

  logic [LEN_W-1:0] active_q, active_n;
  slew_dir_e        dir;
  logic             act_en;

  always_comb begin
    if (active_q < target_i)      dir = SLEW_UP;
    else if (active_q > target_i) dir = SLEW_DOWN;
    else                          dir = SLEW_HOLD;
  end

  always_comb begin
    act_en = sample_i && (dir != SLEW_HOLD);
    unique case (dir)
      SLEW_UP:   active_n = active_q + STEP_V;
      SLEW_DOWN: active_n = active_q - STEP_V;
      default:   active_n = active_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active_q <= INIT_LEN;
    else if (act_en) active_q <= active_n;
  end

  assign active_o = active_q;

  AST_ACT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(active_q)); // R9
  AST_ACT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && active_q < target_i) |=> (active_q == $past(active_q) + STEP_V)); // R9
  AST_ACT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && active_q > target_i) |=> (active_q == $past(active_q) - STEP_V)); // R9
  AST_ACT_MEET: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q == target_i) |=> $stable(active_q)); // R9

endmodule

// File: rtl/buflen_ctrl.sv
module buflen_ctrl #(
  parameter int               ADC_W    = 10,
  parameter int               BLK_LOG2 = 8,
  parameter int               LEN_W    = 16,
  parameter int               STEP     = 2,
  parameter logic [LEN_W-1:0] MIN_LEN  = 16'h0200,
  parameter logic [LEN_W-1:0] DEADBAND = 16'h0040,
  parameter logic [LEN_W-1:0] INIT_LEN = 16'h0600,
  localparam int              ACC_W    = ADC_W + BLK_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_valid_i,
  input  logic [ADC_W-1:0] adc_data_i,
  input  logic             sample_i,
  output logic [LEN_W-1:0] target_len_o,
  output logic [LEN_W-1:0] active_len_o
);

  logic             rst_sync_n;
  logic             blk_done;
  logic [ACC_W-1:0] blk_sum;
  logic [LEN_W-1:0] target_len;

  buflen_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  buflen_accum #(.ADC_W(ADC_W), .BLK_LOG2(BLK_LOG2)) i_accum (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .adc_valid_i (adc_valid_i),
    .adc_data_i  (adc_data_i),
    .blk_done_o  (blk_done),
    .blk_sum_o   (blk_sum)
  );

  buflen_target #(
    .ACC_W(ACC_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN),
    .DEADBAND(DEADBAND), .INIT_LEN(INIT_LEN)
  ) i_target (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .blk_done_i (blk_done),
    .blk_sum_i  (blk_sum),
    .target_o   (target_len)
  );

  buflen_slew #(.LEN_W(LEN_W), .STEP(STEP), .INIT_LEN(INIT_LEN)) i_slew (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sample_i (sample_i),
    .target_i (target_len),
    .active_o (active_len_o)
  );

  assign target_len_o = target_len;

endmodule

// File: tb/test_buflen_ctrl.sv
module test_buflen_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adc_valid_i;
  logic [9:0]  adc_data_i;
  logic        sample_i;
  logic [15:0] target_len_o;
  logic [15:0] active_len_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  logic [15:0] cur_tgt;

  always #4 clk = ~clk;

  buflen_ctrl i_buflen_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .adc_valid_i  (adc_valid_i),
    .adc_data_i   (adc_data_i),
    .sample_i     (sample_i),
    .target_len_o (target_len_o),
    .active_len_o (active_len_o)
  );

  // {base reading x255, final reading, expected target}
  localparam logic [47:0] VEC [8] = '{
    {16'd4,    16'd4,    16'h0200},  // R4 sum 1024 -> 0x100 -> floor
    {16'd512,  16'd516,  16'h8000},  // R3 R6 0x8001 -> even
    {16'd512,  16'd764,  16'h8000},  // R5 diff 0x3F -> hold
    {16'd512,  16'd768,  16'h8040},  // R5 R7 diff 0x40 -> update
    {16'd300,  16'd300,  16'h4B00},  // R3
    {16'd1023, 16'd1023, 16'hFFC0},  // R3 full scale
    {16'd7,    16'd7,    16'h0200},  // R4 0x1C0 -> floor
    {16'd8,    16'd8,    16'h0200}   // R5 equal -> hold
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic feed_rd(input logic [9:0] v);
    adc_valid_i = 1'b1;
    adc_data_i  = v;
    @(negedge clk);
    adc_valid_i = 1'b0;
    adc_data_i  = 10'h3FF;
  endtask

  task automatic run_block(input logic [15:0] base, input logic [15:0] last, input logic [15:0] exp);
    for (int i = 0; i < 255; i++) begin
      feed_rd(base[9:0]);
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R2 no update after 255 readings", target_len_o, cur_tgt);
    feed_rd(last[9:0]);
    check("R8 target unchanged one edge after last reading", target_len_o, cur_tgt);
    @(negedge clk);
    check("R8 R3 R4 R5 R6 R7 block result", target_len_o, exp);
    cur_tgt = exp;
    @(negedge clk);
  endtask

  task automatic strobe();
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
  endtask

  initial begin
    rst_n       = 1'b0;
    adc_valid_i = 1'b0;
    adc_data_i  = '0;
    sample_i    = 1'b0;
    cur_tgt     = 16'h0600;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset target", target_len_o, 16'h0600);
    check("R1 reset active", active_len_o, 16'h0600);

    strobe();
    check("R9 hold when equal", active_len_o, 16'h0600);

    for (int v = 0; v < 8; v++) begin
      run_block(VEC[v][47:32], VEC[v][31:16], VEC[v][15:0]);
    end

    // target now 0x0200, active 0x0600
    strobe(); strobe(); strobe();
    check("R9 step down", active_len_o, 16'h05FA);
    repeat (5) @(negedge clk);
    check("R9 hold without strobe", active_len_o, 16'h05FA);

    run_block(16'd1023, 16'd1023, 16'hFFC0);
    strobe(); strobe();
    check("R9 step up", active_len_o, 16'h05FE);

    run_block(16'd24, 16'd24, 16'h0600);
    strobe();
    check("R9 reach target", active_len_o, 16'h0600);
    strobe();
    check("R9 hold at target", active_len_o, 16'h0600);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule